// File: doc/BRIEF.md
# Nested Trap-Level State Stack

This block handles trap entry and trap return for a processor that nests traps by level. It keeps a trap-level counter and, for each level, one saved frame. A frame holds the interrupted program counter, the next program counter, the trap type, and a packed context word made from the condition codes, the address-space identifier, the processor-state word and the window pointer. The processor presents its current architectural state on the `cur_*` inputs and pulses one command strobe. One clock later the block presents the new architectural state on the `upd_*` outputs, qualified by `upd_valid`.

A trap entry saves the current state in the slot of the current level. It then forms a vector address from the trap base, the level and the trap type, forces the processor state to privileged mode with floating point enabled and alternate globals selected, and raises the level. When the stack is close to its limit, the block enters the error-recovery (red) state instead of continuing normally. A done or retry command lowers the level and restores the saved context. Done resumes after the trapped instruction and retry re-executes it. Commands that cannot be honoured leave all state unchanged and pulse an error flag.

The processor-state word is 12 bits. Its bit positions are: alternate globals = bit 0, privileged = bit 2, FP enable = bit 4, red state = bit 5. Inside the block the saved context word is laid out as condition codes at bits 39:32, address-space identifier at bits 31:24, processor state at bits 19:8 and window pointer at bits 7:0.

Top module: `trapstk_ctrl`

## Requirements
- R1: After a synchronous active-low reset: `tl_o` is 0, `upd_valid` is 0, `err_o` is 0 and `tt_top` is 0.
- R2: An accepted trap produces these outputs one cycle after the strobe: `upd_valid`=1, `upd_npc` = `upd_pc` + 4, `upd_pstate` = 12'h015 (bits 0, 2 and 4 set), and `upd_ccr`, `upd_asi`, `upd_cwp` equal to the current inputs.
- R3: The trap vector `upd_pc` is `cur_tba` with bits 14:0 replaced. Bit 14 is 1 only when the level before the trap is greater than 1. Bits 13:5 hold the trap type. Bits 4:0 are 0.
- R4: An accepted trap raises `tl_o` by one. When the level before the trap is MAXTL-1 or higher, `upd_pstate` also has bit 5 set (12'h035).
- R5: A trap requested while `tl_o` equals MAXTL is not processed. `upd_valid` stays 0, `err_o` pulses, and `tl_o` and `tt_top` are unchanged.
- R6: A done at a level above 0 lowers `tl_o` by one. It sets `upd_pc` to the saved next PC and `upd_npc` to the saved next PC + 4, and it restores condition codes, address-space identifier, the 12-bit processor state and the window pointer from the frame of the new level.
- R7: A retry at a level above 0 lowers `tl_o` by one. It sets `upd_pc` to the saved PC and `upd_npc` to the saved next PC, and it restores the same context fields as R6.
- R8: A done or retry at level 0 is ignored. `err_o` pulses, `upd_valid` stays 0 and `tl_o` stays 0.
- R9: When strobes coincide, a trap request takes precedence over retry, and retry takes precedence over done. The losing commands have no effect even when the winner is rejected.
- R10: `tt_top` shows the trap type saved for level `tl_o`-1 while `tl_o` > 0.
- R11: In a cycle with no strobe, `upd_valid` and `err_o` are 0 in the next cycle and `tl_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap entry strobe |
| done_req | input | 1 | Done strobe |
| retry_req | input | 1 | Retry strobe |
| trap_type | input | 9 | Type of the trap being entered |
| cur_pc | input | VA_W | Current program counter |
| cur_npc | input | VA_W | Current next program counter |
| cur_tba | input | VA_W | Trap base address |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor-state word |
| cur_cwp | input | 8 | Current window pointer |
| upd_valid | output | 1 | New architectural state is valid this cycle |
| upd_pc | output | VA_W | New program counter |
| upd_npc | output | VA_W | New next program counter |
| upd_ccr | output | 8 | New condition codes |
| upd_asi | output | 8 | New address-space identifier |
| upd_pstate | output | 12 | New processor-state word |
| upd_cwp | output | 8 | New window pointer |
| tl_o | output | $clog2(MAXTL+1) | Current trap level |
| tt_top | output | 9 | Trap type of the innermost active level |
| err_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
Trap entry and return are the two functions that can fall in the same cycle, and retry and done can also coincide. The bench provokes these cases by raising combinations of strobes together. It does this at an intermediate level, where the trap must win and the level must rise. It also does it at the maximum level, where the trap is rejected and the return request must still leave the level unchanged. Each case is judged against a reference stack in the bench that applies only the highest-priority command. The bench compares the level, the error pulse, the valid flag and the restored or vectored fields against that reference.

// File: rtl/trapstk_pkg.sv
// Package: shared types and constants of the trap-level stack.
// Assumes a 12-bit processor-state word and a 9-bit trap type.
package trapstk_pkg;
    localparam int TT_W   = 9;
    localparam int CTX_W  = 40;
    localparam int PS_AG   = 0;
    localparam int PS_PRIV = 2;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;
    localparam logic [11:0] PS_ON_ENTRY =
        12'((1 << PS_PEF) | (1 << PS_PRIV) | (1 << PS_AG));
    localparam logic [11:0] PS_RED_BIT = 12'(1 << PS_RED);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_ENTER = 2'd1,
        OP_DONE  = 2'd2,
        OP_RETRY = 2'd3
    } trap_op_e;

    typedef struct packed {
        logic [7:0]  ccr;
        logic [7:0]  asi;
        logic [11:0] pstate;
        logic [7:0]  cwp;
    } ctx_t;

    // Pack a context into the saved-state word layout
    function automatic logic [CTX_W-1:0] ctx_pack(ctx_t c);
        return {c.ccr, c.asi, 4'b0000, c.pstate, c.cwp};
    endfunction

    // Recover a context from a saved-state word
    function automatic ctx_t ctx_unpack(logic [CTX_W-1:0] w);
        ctx_t c;
        c.ccr    = w[39:32];
        c.asi    = w[31:24];
        c.pstate = w[19:8];
        c.cwp    = w[7:0];
        return c;
    endfunction
endpackage

// File: rtl/trapstk_level.sv
// Module: trap-level counter and command arbiter.
// Picks one command per cycle (trap > retry > done), decides whether it is
// accepted, and keeps the level register. Assumes MAXTL >= 2.
module trapstk_level
    import trapstk_pkg::*;
#(
    parameter int MAXTL = 5,
    parameter int TL_W  = $clog2(MAXTL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic            done_req,
    input  logic            retry_req,
    output trap_op_e        op,
    output logic            reject,
    output logic            red_entry,
    output logic [TL_W-1:0] tl_q
);
    localparam logic [TL_W-1:0] TL_TOP  = TL_W'(MAXTL);
    localparam logic [TL_W-1:0] TL_NEAR = TL_W'(MAXTL - 1);

    logic at_top;
    logic at_floor;

    assign at_top   = (tl_q == TL_TOP);
    assign at_floor = (tl_q == '0);

    // Arbitrate the strobes and classify the winner as accepted or rejected
    always_comb begin
        op     = OP_IDLE;
        reject = 1'b0;
        if (trap_req) begin
            if (at_top) reject = 1'b1;
            else        op     = OP_ENTER;
        end else if (retry_req || done_req) begin
            if (at_floor)       reject = 1'b1;
            else if (retry_req) op     = OP_RETRY;
            else                op     = OP_DONE;
        end
    end

    assign red_entry = (tl_q >= TL_NEAR);

    // Level register: up on accepted entry, down on accepted return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q <= '0;
        end else begin
            case (op)
                OP_ENTER:         tl_q <= tl_q + TL_W'(1);
                OP_DONE, OP_RETRY: tl_q <= tl_q - TL_W'(1);
                default:          tl_q <= tl_q;
            endcase
        end
    end
endmodule

// File: rtl/trapstk_frames.sv
// Module: per-level saved-frame storage.
// One register slot per level, one write port and one combinational read port.
// Assumes the write index is always below DEPTH when wr_en is high.
module trapstk_frames
    import trapstk_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int VA_W  = 64,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_pc,
    input  logic [VA_W-1:0]  wr_npc,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [TT_W-1:0]  wr_tt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VA_W-1:0]  rd_pc,
    output logic [VA_W-1:0]  rd_npc,
    output logic [CTX_W-1:0] rd_ctx,
    output logic [TT_W-1:0]  rd_tt
);
    logic [VA_W-1:0]  pc_mem  [DEPTH];
    logic [VA_W-1:0]  npc_mem [DEPTH];
    logic [CTX_W-1:0] ctx_mem [DEPTH];
    logic [TT_W-1:0]  tt_mem  [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Capture the frame when this slot is addressed by an entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_mem[s]  <= '0;
                npc_mem[s] <= '0;
                ctx_mem[s] <= '0;
                tt_mem[s]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                pc_mem[s]  <= wr_pc;
                npc_mem[s] <= wr_npc;
                ctx_mem[s] <= wr_ctx;
                tt_mem[s]  <= wr_tt;
            end
        end
    end

    // Read mux guarded against indices beyond the last slot
    always_comb begin
        rd_pc  = '0;
        rd_npc = '0;
        rd_ctx = '0;
        rd_tt  = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (rd_idx == IDX_W'(s)) begin
                rd_pc  = pc_mem[s];
                rd_npc = npc_mem[s];
                rd_ctx = ctx_mem[s];
                rd_tt  = tt_mem[s];
            end
        end
    end
endmodule

// File: rtl/trapstk_vector.sv
// Module: trap vector address former.
// Replaces the low 15 bits of the trap base with a level flag and the trap
// type. Assumes VA_W >= 16.
module trapstk_vector
    import trapstk_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int TL_W = 3
) (
    input  logic [VA_W-1:0] tba,
    input  logic [TL_W-1:0] tl,
    input  logic [TT_W-1:0] tt,
    output logic [VA_W-1:0] vec
);
    logic nested;

    assign nested = (tl > TL_W'(1));
    // Upper base bits, nesting flag, type, 32-byte slot alignment
    assign vec = {tba[VA_W-1:15], nested, tt, 5'b00000};
endmodule

// File: rtl/trapstk_ctrl.sv
// Module: top of the nested trap-level state stack.
// Saves the current state on trap entry and restores it on done or retry.
// All updates are registered and appear one cycle after the strobe.
// Assumes MAXTL >= 2 and VA_W >= 16; the caller applies upd_* when upd_valid.
module trapstk_ctrl
    import trapstk_pkg::*;
#(
    parameter int MAXTL = 5,
    parameter int VA_W  = 64,
    localparam int TL_W  = $clog2(MAXTL + 1),
    localparam int IDX_W = $clog2(MAXTL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic            done_req,
    input  logic            retry_req,
    input  logic [8:0]      trap_type,
    input  logic [VA_W-1:0] cur_pc,
    input  logic [VA_W-1:0] cur_npc,
    input  logic [VA_W-1:0] cur_tba,
    input  logic [7:0]      cur_ccr,
    input  logic [7:0]      cur_asi,
    input  logic [11:0]     cur_pstate,
    input  logic [7:0]      cur_cwp,
    output logic            upd_valid,
    output logic [VA_W-1:0] upd_pc,
    output logic [VA_W-1:0] upd_npc,
    output logic [7:0]      upd_ccr,
    output logic [7:0]      upd_asi,
    output logic [11:0]     upd_pstate,
    output logic [7:0]      upd_cwp,
    output logic [TL_W-1:0] tl_o,
    output logic [8:0]      tt_top,
    output logic            err_o
);
    trap_op_e         op;
    logic             reject;
    logic             red_entry;
    logic [TL_W-1:0]  tl_q;
    logic [VA_W-1:0]  vec;
    logic [VA_W-1:0]  sv_pc;
    logic [VA_W-1:0]  sv_npc;
    logic [CTX_W-1:0] sv_ctx;
    logic [TT_W-1:0]  sv_tt;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    ctx_t             cur_ctx;
    ctx_t             back_ctx;

    trapstk_level #(.MAXTL(MAXTL), .TL_W(TL_W)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_req  (trap_req),
        .done_req  (done_req),
        .retry_req (retry_req),
        .op        (op),
        .reject    (reject),
        .red_entry (red_entry),
        .tl_q      (tl_q)
    );

    assign wr_idx = IDX_W'(tl_q);
    assign rd_idx = IDX_W'(tl_q - TL_W'(1));

    assign cur_ctx.ccr    = cur_ccr;
    assign cur_ctx.asi    = cur_asi;
    assign cur_ctx.pstate = cur_pstate;
    assign cur_ctx.cwp    = cur_cwp;

    trapstk_frames #(.DEPTH(MAXTL), .VA_W(VA_W), .IDX_W(IDX_W)) u_frames (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (op == OP_ENTER),
        .wr_idx (wr_idx),
        .wr_pc  (cur_pc),
        .wr_npc (cur_npc),
        .wr_ctx (ctx_pack(cur_ctx)),
        .wr_tt  (trap_type),
        .rd_idx (rd_idx),
        .rd_pc  (sv_pc),
        .rd_npc (sv_npc),
        .rd_ctx (sv_ctx),
        .rd_tt  (sv_tt)
    );

    trapstk_vector #(.VA_W(VA_W), .TL_W(TL_W)) u_vector (
        .tba (cur_tba),
        .tl  (tl_q),
        .tt  (trap_type),
        .vec (vec)
    );

    assign back_ctx = ctx_unpack(sv_ctx);

    // Produce the next architectural state for the accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid  <= 1'b0;
            err_o      <= 1'b0;
            upd_pc     <= '0;
            upd_npc    <= '0;
            upd_ccr    <= '0;
            upd_asi    <= '0;
            upd_pstate <= '0;
            upd_cwp    <= '0;
        end else begin
            upd_valid <= (op != OP_IDLE);
            err_o     <= reject;
            case (op)
                OP_ENTER: begin
                    upd_pc     <= vec;
                    upd_npc    <= vec + VA_W'(4);
                    upd_ccr    <= cur_ccr;
                    upd_asi    <= cur_asi;
                    upd_pstate <= red_entry ? (PS_ON_ENTRY | PS_RED_BIT) : PS_ON_ENTRY;
                    upd_cwp    <= cur_cwp;
                end
                OP_DONE, OP_RETRY: begin
                    upd_pc     <= (op == OP_RETRY) ? sv_pc  : sv_npc;
                    upd_npc    <= (op == OP_RETRY) ? sv_npc : sv_npc + VA_W'(4);
                    upd_ccr    <= back_ctx.ccr;
                    upd_asi    <= back_ctx.asi;
                    upd_pstate <= back_ctx.pstate;
                    upd_cwp    <= back_ctx.cwp;
                end
                default: ;
            endcase
        end
    end

    assign tl_o   = tl_q;
    assign tt_top = (tl_q != '0) ? sv_tt : '0;
endmodule

// File: rtl/trapstk_ctrl_chk.sv
// Module: temporal checks on the trap-level stack ports, bound to the top.
module trapstk_ctrl_chk #(
    parameter int MAXTL = 5,
    parameter int VA_W  = 64,
    parameter int TL_W  = $clog2(MAXTL + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic            done_req,
    input logic            retry_req,
    input logic            upd_valid,
    input logic [VA_W-1:0] upd_pc,
    input logic [VA_W-1:0] upd_npc,
    input logic [11:0]     upd_pstate,
    input logic [TL_W-1:0] tl_o,
    input logic            err_o
);
    // R2
    entry_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_o != TL_W'(MAXTL)) |=>
            (upd_valid && !err_o && upd_npc == upd_pc + VA_W'(4)
             && upd_pstate[0] && upd_pstate[2] && upd_pstate[4]));

    // R4
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_o != TL_W'(MAXTL)) |=> (tl_o == $past(tl_o) + TL_W'(1)));

    // R5
    top_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_o == TL_W'(MAXTL)) |=> (err_o && !upd_valid && $stable(tl_o)));

    // R6
    level_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && (done_req || retry_req) && tl_o != '0) |=>
            (upd_valid && tl_o == $past(tl_o) - TL_W'(1)));

    // R8
    floor_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && (done_req || retry_req) && tl_o == '0) |=>
            (err_o && !upd_valid && tl_o == '0));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !done_req && !retry_req) |=> (!upd_valid && !err_o && $stable(tl_o)));

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tl_o <= TL_W'(MAXTL));
endmodule

bind trapstk_ctrl trapstk_ctrl_chk #(.MAXTL(MAXTL), .VA_W(VA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .done_req   (done_req),
    .retry_req  (retry_req),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_npc    (upd_npc),
    .upd_pstate (upd_pstate),
    .tl_o       (tl_o),
    .err_o      (err_o)
);

// File: tb/tb_trapstk_ctrl.sv
// Bench: sweeps trap types and levels against a reference stack model.
module tb_trapstk_ctrl;
    localparam int MAXTL = 5;
    localparam int VA_W  = 64;
    localparam int TL_W  = $clog2(MAXTL + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0, done_req = 1'b0, retry_req = 1'b0;
    logic [8:0]      trap_type = '0;
    logic [VA_W-1:0] cur_pc = '0, cur_npc = '0, cur_tba = '0;
    logic [7:0]      cur_ccr = '0, cur_asi = '0, cur_cwp = '0;
    logic [11:0]     cur_pstate = '0;
    logic            upd_valid, err_o;
    logic [VA_W-1:0] upd_pc, upd_npc;
    logic [7:0]      upd_ccr, upd_asi, upd_cwp;
    logic [11:0]     upd_pstate;
    logic [TL_W-1:0] tl_o;
    logic [8:0]      tt_top;

    int n_cmp = 0;
    int n_bad = 0;
    int seq = 0;
    bit finished = 1'b0;

    // Reference stack
    logic [VA_W-1:0] m_pc [MAXTL];
    logic [VA_W-1:0] m_npc[MAXTL];
    logic [7:0]      m_ccr[MAXTL], m_asi[MAXTL], m_cwp[MAXTL];
    logic [11:0]     m_ps [MAXTL];
    logic [8:0]      m_tt [MAXTL];
    int              m_tl = 0;

    always #10 clk = ~clk;

    trapstk_ctrl #(.MAXTL(MAXTL), .VA_W(VA_W)) dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .done_req(done_req),
        .retry_req(retry_req), .trap_type(trap_type), .cur_pc(cur_pc),
        .cur_npc(cur_npc), .cur_tba(cur_tba), .cur_ccr(cur_ccr),
        .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_cwp(cur_cwp),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_npc(upd_npc),
        .upd_ccr(upd_ccr), .upd_asi(upd_asi), .upd_pstate(upd_pstate),
        .upd_cwp(upd_cwp), .tl_o(tl_o), .tt_top(tt_top), .err_o(err_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One command; t/d/r are the strobes, tt the trap type; checks next cycle
    task automatic cmd(input bit t, input bit d, input bit r, input logic [8:0] tt, input string req);
        logic [VA_W-1:0] e_pc, e_npc, vecb;
        logic [7:0]      e_ccr, e_asi, e_cwp;
        logic [11:0]     e_ps;
        bit              e_val, e_err;
        int              op;
        @(negedge clk);
        seq++;
        cur_pc     = 64'h0000_4000_0000_0000 + 64'(seq) * 64'h100;
        cur_npc    = cur_pc + 64'h24;
        cur_tba    = 64'hFFFF_0000_1234_5678 ^ (64'(seq) << 20);
        cur_ccr    = 8'(seq * 3);
        cur_asi    = 8'(seq) ^ 8'h5A;
        cur_pstate = 12'hA40 ^ 12'(seq);
        cur_cwp    = 8'(seq % 8);
        trap_type  = tt;
        trap_req = t; done_req = d; retry_req = r;
        e_val = 0; e_err = 0;
        e_pc = '0; e_npc = '0; e_ccr = '0; e_asi = '0; e_cwp = '0; e_ps = '0;
        op = t ? 1 : (r ? 3 : (d ? 2 : 0));
        if (op == 1) begin
            if (m_tl == MAXTL) e_err = 1;
            else begin
                e_val = 1;
                m_pc[m_tl] = cur_pc; m_npc[m_tl] = cur_npc; m_ccr[m_tl] = cur_ccr;
                m_asi[m_tl] = cur_asi; m_ps[m_tl] = cur_pstate; m_cwp[m_tl] = cur_cwp;
                m_tt[m_tl] = tt;
                vecb = (cur_tba & ~64'h7FFF) | ((m_tl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
                e_pc = vecb; e_npc = vecb + 4;
                e_ccr = cur_ccr; e_asi = cur_asi; e_cwp = cur_cwp;
                e_ps = (m_tl >= MAXTL - 1) ? 12'h035 : 12'h015;
                m_tl++;
            end
        end else if (op != 0) begin
            if (m_tl == 0) e_err = 1;
            else begin
                e_val = 1;
                m_tl--;
                e_pc  = (op == 3) ? m_pc[m_tl] : m_npc[m_tl];
                e_npc = (op == 3) ? m_npc[m_tl] : m_npc[m_tl] + 4;
                e_ccr = m_ccr[m_tl]; e_asi = m_asi[m_tl];
                e_ps = m_ps[m_tl]; e_cwp = m_cwp[m_tl];
            end
        end
        @(negedge clk);
        trap_req = 0; done_req = 0; retry_req = 0;
        check({req, " valid"}, 64'(upd_valid), 64'(e_val));
        check({req, " err"}, 64'(err_o), 64'(e_err));
        check({req, " level"}, 64'(tl_o), 64'(m_tl));
        // R10: innermost trap type
        check("R10 tt_top", 64'(tt_top), (m_tl > 0) ? 64'(m_tt[m_tl-1]) : 64'h0);
        if (e_val) begin
            check({req, " pc"}, upd_pc, e_pc);
            check({req, " npc"}, upd_npc, e_npc);
            check({req, " ccr"}, 64'(upd_ccr), 64'(e_ccr));
            check({req, " asi"}, 64'(upd_asi), 64'(e_asi));
            check({req, " pstate"}, 64'(upd_pstate), 64'(e_ps));
            check({req, " cwp"}, 64'(upd_cwp), 64'(e_cwp));
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 level", 64'(tl_o), 64'h0);
        check("R1 valid", 64'(upd_valid), 64'h0);
        check("R1 err", 64'(err_o), 64'h0);
        check("R1 tt_top", 64'(tt_top), 64'h0);
        rst_n = 1'b1;
        // R8: return at level 0
        cmd(0, 1, 0, 9'h0, "R8 done at floor");
        cmd(0, 0, 1, 9'h0, "R8 retry at floor");
        // R2/R3: trap type sweep from levels 0 and 1 and 2
        for (int k = 0; k < 512; k += 7) begin
            cmd(1, 0, 0, 9'(k), "R2 R3 entry sweep");
            cmd(1, 0, 0, 9'(511 - k), "R3 nested vector");
            cmd(1, 0, 0, 9'(k ^ 9'h155), "R3 deep vector");
            cmd(0, 0, 1, 9'h0, "R7 retry unwind");
            cmd(0, 1, 0, 9'h0, "R6 done unwind");
            cmd(0, 0, 1, 9'h0, "R7 retry to floor");
        end
        // R4: fill to the top, red state on last entries
        for (int l = 0; l < MAXTL; l++) cmd(1, 0, 0, 9'(37 * l + 3), "R4 fill");
        // R5: rejected at top
        cmd(1, 0, 0, 9'h1FF, "R5 top reject");
        // R9: trap with done at top is rejected, done not applied
        cmd(1, 1, 0, 9'h0AA, "R9 trap over done at top");
        // R11: idle
        cmd(0, 0, 0, 9'h0, "R11 idle");
        // R6/R7: unwind alternating
        for (int l = 0; l < MAXTL; l++) begin
            if (l % 2 == 0) cmd(0, 1, 0, 9'h0, "R6 done");
            else            cmd(0, 0, 1, 9'h0, "R7 retry");
        end
        cmd(0, 1, 1, 9'h0, "R8 both at floor");
        // R9: coincident strobes at an intermediate level
        cmd(1, 0, 0, 9'h011, "R9 setup");
        cmd(1, 1, 1, 9'h022, "R9 trap wins");
        cmd(0, 1, 1, 9'h0, "R9 retry beats done");
        cmd(0, 1, 0, 9'h0, "R9 done");
        cmd(0, 0, 0, 9'h0, "R11 idle end");
        finish_run();
    end
endmodule